// File: doc/BRIEF.md
# Banked Cartridge Memory Mapper with Single-Screen Page Select

This block sits between a console CPU and the cartridge ROMs. It takes CPU writes to the upper half of the address space and turns them into bank numbers. There are four 8 KB program windows on the CPU side and eight 1 KB character windows on the picture-processor side. Two registers are reachable through the writes. A select register picks a bank slot and holds two layout mode bits. A data register loads the bank slot that the select register points at.

The nametable page is set by the same bank writes. It is a single-screen page choice, and it is updated only by a write to the character bank that currently sits in picture window 0. The number of program banks on the cartridge is a parameter, and the two fixed top banks are derived from it. A configuration input tells the block whether the cartridge carries character ROM.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write is decoded from address bits 15, 14, 13 and 0 only. Bits 15..13 equal to 3'b100 with bit 0 = 0 write the select register. The same bits with bit 0 = 1 write the data register. Every other address bit is ignored, so 0x9FFE aliases the select register.
- R2: A write whose address bits 15..13 are not 3'b100 changes no output. This covers addresses below 0x8000 and the masked addresses 0xA000, 0xA001, 0xC000, 0xC001, 0xE000 and 0xE001.
- R3: Slots 0 and 1 (select bits 2..0) hold 2 KB character banks, and the written data has bit 0 forced to 0. Each such bank feeds two adjacent windows with the values b and b|1.
- R4: Slots 2, 3, 4 and 5 hold 1 KB character banks that feed one window each. Slot 6 loads program bank A and slot 7 loads program bank B.
- R5: When select bit 6 = 0, program windows 0..3 (CPU 0x8000, 0xA000, 0xC000, 0xE000) show A, B, N-2, N-1. When select bit 6 = 1, they show N-2, B, A, N-1.
- R6: When select bit 7 = 0, character windows 0..7 show s0, s0|1, s1, s1|1, s2, s3, s4, s5, where sK is slot K. When select bit 7 = 1, windows 0..3 and 4..7 trade places.
- R7: The page output mirror_hi_o is updated only by a data write to slot 0 while select bit 7 = 0, or to slot 2 while select bit 7 = 1. It becomes 1 (high page) when data bit 7 = 0, and 0 (low page) when data bit 7 = 1. No other write changes it.
- R8: After reset the select register is 0, bank A = 0, bank B = 1 and mirror_hi_o = 0. The character slots 0..5 are 0, 2, 4, 5, 6, 7 when character ROM is present.
- R9: When chr_rom_present = 0, reset leaves all character slots at 0 and data writes to slots 0..5 are ignored. Program bank and page writes still take effect.
- R10: All outputs come from registers. A write strobe sampled at a rising edge shows at the outputs just after that edge, and outputs are stable in any cycle without an accepted write.
- R11: The fixed program banks are N-1 and N-2, where N is the parameter PRG_BANKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chr_rom_present | input | 1 | 1 when the cartridge carries character ROM |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | BANK_W (8) | CPU write data |
| prg_bank_o | output | 4*BANK_W | Program bank numbers, window k at bits [k*BANK_W +: BANK_W] |
| chr_bank_o | output | 8*BANK_W | Character bank numbers, window k at bits [k*BANK_W +: BANK_W] |
| mirror_hi_o | output | 1 | Single-screen page: 1 = high page, 0 = low page |

## Verification
Every result of a write is due one rising edge after the edge that samples the strobe. No result waits on a second edge, and the page bit has the same timing as the bank numbers. The bench drives inputs on the falling edge and first checks, before the next rising edge, that nothing has moved yet. It then samples on the falling edge that follows, where the new values must be present. The reference model is updated in that same half cycle, so every random and directed write is checked with exactly one edge of latency.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_SEL  = 2'd1,
    WK_DATA = 2'd2
  } wr_kind_e;

  // Address key: bits 15..13 must be 3'b100, bit 0 picks the register
  function automatic wr_kind_e decode_kind(input logic en,
                                           input logic [2:0] top3,
                                           input logic lsb);
    if (!en || top3 != 3'b100) return WK_NONE;
    return lsb ? WK_DATA : WK_SEL;
  endfunction

  // Reset value of a character slot (0..5)
  function automatic logic [7:0] chr_reset_val(input int slot, input logic present);
    if (!present) return 8'd0;
    if (slot == 0) return 8'd0;
    if (slot == 1) return 8'd2;
    return 8'(slot + 2);
  endfunction

  // Slot whose bank lands in picture window 0
  function automatic logic [2:0] window0_slot(input logic swap);
    return swap ? 3'd2 : 3'd0;
  endfunction

endpackage

// File: rtl/cbm_decode.sv
module cbm_decode
  import cbm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              sel_wr,
  output logic              data_wr
);
  wr_kind_e kind;
  logic     unused_addr;

  always_comb begin
    kind    = decode_kind(wr_en, wr_addr[ADDR_W-1:ADDR_W-3], wr_addr[0]);
    sel_wr  = (kind == WK_SEL);
    data_wr = (kind == WK_DATA);
  end

  assign unused_addr = ^wr_addr[ADDR_W-4:1];
endmodule

// File: rtl/cbm_regfile.sv
module cbm_regfile
  import cbm_pkg::*;
#(
  parameter int BANK_W   = 8,
  parameter int CHR_REGS = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           chr_rom_present,
  input  logic                           sel_wr,
  input  logic                           data_wr,
  input  logic                           mirror_upd,
  input  logic [BANK_W-1:0]              wr_data,
  output logic [BANK_W-1:0]              bank_sel,
  output logic [BANK_W-1:0]              prg_a,
  output logic [BANK_W-1:0]              prg_b,
  output logic [CHR_REGS-1:0][BANK_W-1:0] chr_slot,
  output logic                           mirror_hi
);
  localparam int SLOT_W = 3;

  logic [SLOT_W-1:0] target;
  assign target = bank_sel[SLOT_W-1:0];

  // select register and program banks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_sel <= '0;
      prg_a    <= BANK_W'(0);
      prg_b    <= BANK_W'(1);
    end else begin
      if (sel_wr) bank_sel <= wr_data;
      if (data_wr && target == 3'd6) prg_a <= wr_data;
      if (data_wr && target == 3'd7) prg_b <= wr_data;
    end
  end

  // character slots, one register per slot
  for (genvar s = 0; s < CHR_REGS; s++) begin : g_chr
    logic [BANK_W-1:0] load_val;
    if (s < 2) begin : g_wide
      assign load_val = {wr_data[BANK_W-1:1], 1'b0};
    end else begin : g_narrow
      assign load_val = wr_data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)
        chr_slot[s] <= BANK_W'(chr_reset_val(s, chr_rom_present));
      else if (data_wr && chr_rom_present && target == SLOT_W'(s))
        chr_slot[s] <= load_val;
    end
  end

  // single-screen page
  always_ff @(posedge clk) begin
    if (!rst_n)          mirror_hi <= 1'b0;
    else if (mirror_upd) mirror_hi <= ~wr_data[BANK_W-1];
  end
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map #(
  parameter int PRG_BANKS = 32,
  parameter int BANK_W    = 8,
  parameter int WINDOWS   = 4
) (
  input  logic                          swap_low,
  input  logic [BANK_W-1:0]             prg_a,
  input  logic [BANK_W-1:0]             prg_b,
  output logic [WINDOWS-1:0][BANK_W-1:0] win
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(PRG_BANKS - 1);
  localparam logic [BANK_W-1:0] PREV_BANK = BANK_W'(PRG_BANKS - 2);

  function automatic logic [BANK_W-1:0] pick(input int w, input logic sw,
                                             input logic [BANK_W-1:0] a,
                                             input logic [BANK_W-1:0] b);
    case (w)
      0:       return sw ? PREV_BANK : a;
      1:       return b;
      2:       return sw ? a : PREV_BANK;
      default: return LAST_BANK;
    endcase
  endfunction

  for (genvar w = 0; w < WINDOWS; w++) begin : g_win
    assign win[w] = pick(w, swap_low, prg_a, prg_b);
  end
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map #(
  parameter int BANK_W   = 8,
  parameter int CHR_REGS = 6,
  parameter int WINDOWS  = 8
) (
  input  logic                            swap_half,
  input  logic [CHR_REGS-1:0][BANK_W-1:0] chr_slot,
  output logic [WINDOWS-1:0][BANK_W-1:0]  win
);
  localparam int HALF = WINDOWS / 2;

  // Bank seen by window w in the unswapped layout
  function automatic logic [BANK_W-1:0] plain(input int w,
                                              input logic [CHR_REGS-1:0][BANK_W-1:0] s);
    if (w < HALF) return s[w / 2] | BANK_W'(w % 2);
    return s[w - HALF + 2];
  endfunction

  for (genvar w = 0; w < WINDOWS; w++) begin : g_win
    localparam int WSW = (w + HALF) % WINDOWS;
    assign win[w] = swap_half ? plain(WSW, chr_slot) : plain(w, chr_slot);
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int BANK_W    = 8,
  parameter int ADDR_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chr_rom_present,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BANK_W-1:0]     wr_data,
  output logic [4*BANK_W-1:0]   prg_bank_o,
  output logic [8*BANK_W-1:0]   chr_bank_o,
  output logic                  mirror_hi_o
);
  localparam int PRG_WIN  = 4;
  localparam int CHR_WIN  = 8;
  localparam int CHR_REGS = 6;

  // named internal events
  logic                            sel_wr;
  logic                            data_wr;
  logic                            mirror_upd;
  logic [BANK_W-1:0]               bank_sel;
  logic [BANK_W-1:0]               prg_a, prg_b;
  logic [CHR_REGS-1:0][BANK_W-1:0] chr_slot;
  logic [PRG_WIN-1:0][BANK_W-1:0]  prg_win;
  logic [CHR_WIN-1:0][BANK_W-1:0]  chr_win;
  logic                            unused_sel;

  cbm_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .sel_wr  (sel_wr),
    .data_wr (data_wr)
  );

  assign mirror_upd = data_wr && (bank_sel[2:0] == window0_slot(bank_sel[BANK_W-1]));
  assign unused_sel = ^bank_sel[5:3];

  cbm_regfile #(.BANK_W(BANK_W), .CHR_REGS(CHR_REGS)) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .chr_rom_present (chr_rom_present),
    .sel_wr          (sel_wr),
    .data_wr         (data_wr),
    .mirror_upd      (mirror_upd),
    .wr_data         (wr_data),
    .bank_sel        (bank_sel),
    .prg_a           (prg_a),
    .prg_b           (prg_b),
    .chr_slot        (chr_slot),
    .mirror_hi       (mirror_hi_o)
  );

  cbm_prg_map #(.PRG_BANKS(PRG_BANKS), .BANK_W(BANK_W), .WINDOWS(PRG_WIN)) u_prg (
    .swap_low (bank_sel[6]),
    .prg_a    (prg_a),
    .prg_b    (prg_b),
    .win      (prg_win)
  );

  cbm_chr_map #(.BANK_W(BANK_W), .CHR_REGS(CHR_REGS), .WINDOWS(CHR_WIN)) u_chr (
    .swap_half (bank_sel[BANK_W-1]),
    .chr_slot  (chr_slot),
    .win       (chr_win)
  );

  assign prg_bank_o = prg_win;
  assign chr_bank_o = chr_win;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int BANK_W = 8,
  parameter int ADDR_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                chr_rom_present,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [4*BANK_W-1:0] prg_bank_o,
  input logic [8*BANK_W-1:0] chr_bank_o,
  input logic                mirror_hi_o,
  input logic                sel_wr,
  input logic                data_wr,
  input logic                mirror_upd,
  input logic [BANK_W-1:0]   bank_sel
);
  // R10: without a write every output holds
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_hi_o)));

  // R2: writes outside the mapper key change nothing
  assert_foreign_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[ADDR_W-1:ADDR_W-3] != 3'b100)
      |=> ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_hi_o)));

  // R1: the decoder never raises both register strobes
  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_wr, data_wr}));

  // R7: the page only moves after a window-0 bank write
  assert_page_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mirror_hi_o) |-> $past(mirror_upd));

  // R7: a select write leaves the page alone
  assert_page_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> $stable(mirror_hi_o));

  // R9: with no character ROM, slot writes leave character windows unchanged
  assert_no_chr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !chr_rom_present && bank_sel[2:0] < 3'd6) |=> $stable(chr_bank_o));
endmodule

bind cart_bank_mapper cbm_checker #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .chr_rom_present (chr_rom_present),
  .wr_en           (wr_en),
  .wr_addr         (wr_addr),
  .prg_bank_o      (prg_bank_o),
  .chr_bank_o      (chr_bank_o),
  .mirror_hi_o     (mirror_hi_o),
  .sel_wr          (sel_wr),
  .data_wr         (data_wr),
  .mirror_upd      (mirror_upd),
  .bank_sel        (bank_sel)
);

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
  localparam int N  = 32;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chr_rom_present = 1'b1;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [31:0]   prg_bank_o;
  logic [63:0]   chr_bank_o;
  logic          mirror_hi_o;

  int tests = 0;
  int fails = 0;

  // reference state
  logic [7:0] m_sel, m_a, m_b;
  logic [7:0] m_s [6];
  logic       m_mir;

  always #2 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .chr_rom_present(chr_rom_present),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prg_bank_o(prg_bank_o), .chr_bank_o(chr_bank_o), .mirror_hi_o(mirror_hi_o)
  );

  function automatic logic [31:0] exp_prg();
    logic [7:0] w [4];
    w[0] = m_a; w[1] = m_b; w[2] = 8'(N - 2); w[3] = 8'(N - 1);
    if (m_sel[6]) begin w[0] = 8'(N - 2); w[2] = m_a; end
    return {w[3], w[2], w[1], w[0]};
  endfunction

  function automatic logic [63:0] exp_chr();
    logic [7:0] lay [8];
    logic [63:0] r;
    lay[0] = m_s[0]; lay[1] = m_s[0] + 8'd1;
    lay[2] = m_s[1]; lay[3] = m_s[1] + 8'd1;
    for (int i = 0; i < 4; i++) lay[4 + i] = m_s[2 + i];
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = lay[m_sel[7] ? (i ^ 4) : i];
    return r;
  endfunction

  task automatic model_reset();
    m_sel = 0; m_a = 0; m_b = 1; m_mir = 0;
    m_s[0] = chr_rom_present ? 8'd0 : 8'd0;
    m_s[1] = chr_rom_present ? 8'd2 : 8'd0;
    for (int i = 2; i < 6; i++) m_s[i] = chr_rom_present ? 8'(i + 2) : 8'd0;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    logic [2:0] t;
    if (a[15:13] != 3'b100) return;
    if (!a[0]) begin m_sel = d; return; end
    t = m_sel[2:0];
    if ((!m_sel[7] && t == 3'd0) || (m_sel[7] && t == 3'd2)) m_mir = ~d[7];
    case (t)
      3'd6: m_a = d;
      3'd7: m_b = d;
      3'd0, 3'd1: if (chr_rom_present) m_s[t] = d & 8'hFE;
      default: if (chr_rom_present) m_s[t] = d;
    endcase
  endtask

  task automatic check(input string tag);
    tests++;
    if (prg_bank_o !== exp_prg() || chr_bank_o !== exp_chr() || mirror_hi_o !== m_mir) begin
      fails++;
      $display("FAIL %s: prg=%h chr=%h page=%b expected prg=%h chr=%h page=%b",
               tag, prg_bank_o, chr_bank_o, mirror_hi_o, exp_prg(), exp_chr(), m_mir);
    end
  endtask

  // drive at falling edge, confirm no early change, sample one edge later
  task automatic write(input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1 check({tag, " R10 before edge"});
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; model_reset();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: R10 run did not finish, actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    check("R8 reset state with character ROM");
    if (prg_bank_o[31:16] !== {8'(N - 1), 8'(N - 2)}) begin
      fails++; $display("FAIL R11: top=%h expected %h", prg_bank_o[31:16], {8'(N - 1), 8'(N - 2)});
    end
    tests++;

    write(16'h8000, 8'h06, "R1 select slot 6");
    write(16'h8001, 8'h15, "R4 program bank A");
    write(16'h9FFE, 8'h07, "R1 aliased select");
    write(16'h9E03, 8'h2A, "R1 aliased data to bank B");
    write(16'h7FFF, 8'h00, "R2 low address ignored");
    write(16'hA001, 8'h11, "R2 0xA001 ignored");
    write(16'hC000, 8'h12, "R2 0xC000 ignored");
    write(16'hE001, 8'h13, "R2 0xE001 ignored");
    write(16'h8000, 8'h46, "R5 program swap on");
    write(16'h8000, 8'h00, "R3 slot 0 chosen");
    write(16'h8001, 8'h37, "R3 odd data forced even, R7 page high");
    write(16'h8000, 8'h01, "R3 slot 1 chosen");
    write(16'h8001, 8'hC9, "R3 slot 1 and R7 no page update");
    for (int s = 2; s < 6; s++) begin
      write(16'h8000, 8'(s), "R4 select");
      write(16'h8001, 8'(8'h40 + s), "R4 1KB slot");
    end
    write(16'h8000, 8'h82, "R6 halves swapped");
    write(16'h8001, 8'h90, "R7 slot 2 in window 0 sets low page");
    write(16'h8000, 8'h80, "R6 slot 0 with swap");
    write(16'h8001, 8'h10, "R7 slot 0 no page update while swapped");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom_range(3) != 0) a[15:13] = 3'b100;
      write(a, 8'($urandom), "R1 random write");
    end

    chr_rom_present = 1'b0;
    do_reset();
    check("R9 reset without character ROM");
    write(16'h8000, 8'h03, "R9 select slot 3");
    write(16'h8001, 8'h5A, "R9 slot write ignored");
    write(16'h8000, 8'h00, "R9 select slot 0");
    write(16'h8001, 8'h01, "R9 page updates without character ROM");
    write(16'h8000, 8'h07, "R9 select slot 7");
    write(16'h8001, 8'h3C, "R9 program write still works");
    for (int i = 0; i < 100; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom_range(3) != 0) a[15:13] = 3'b100;
      write(a, 8'($urandom), "R9 random write");
    end
    finish_run();
  end
endmodule